// File: doc/BRIEF.md
# Windowed Trigger Watchdog with Confidence Counter

This block supervises a host processor that is expected to toggle a trigger line at a steady rate. An internal clock, independent of the host, times the interval between consecutive rising edges of the trigger. Each edge is judged good when that interval lies inside a configurable window and bad otherwise. The verdicts move a two-bit saturating confidence level up or down. A set/reset flag follows the level: it is set when the level reaches its top value and cleared when the level returns to zero. The flag drives both the watchdog-OK output and the enable output that gates downstream actuators.

Once the flag is set, the acceptance window moves one clock later. A trigger near a window edge therefore cannot flip the verdict on every period. If no trigger arrives for the timeout interval, the confidence level and the flag are cleared and interval timing restarts. An oscillator-fault input and the synchronous reset also force the block into its safe state. With the default parameters the internal clock runs at one hundred times the nominal trigger rate, so the window is centred on 100 clocks.

Top module: `wdt_window_supervisor`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the period count, the confidence level and the OK flag are cleared, so `ok_o` and `enable_o` read 0 after that edge.
- R2: `trig_i` passes through a two-flop synchronizer and then a rising-edge detector. A trigger first sampled high at clock edge n is evaluated at edge n+2, and its result shows on the outputs after that edge. A trigger held high for many clocks is evaluated only once.
- R3: The period of a trigger is the number of clocks between its detection and the previous detection. With the OK flag clear, a period in the closed range [WIN_LO, WIN_HI] (default 80 to 120) is good and any other period is bad.
- R4: A good trigger raises the confidence level by one and a bad trigger lowers it by one. The level saturates at 0 and at 3 and never wraps.
- R5: When the level becomes 3, the OK flag is set. When it becomes 0, the flag is cleared. Levels 1 and 2 leave it unchanged. `ok_o` and `enable_o` both show the flag.
- R6: With the OK flag set, the good range moves to [WIN_LO+1, WIN_HI+1] (default 81 to 121).
- R7: If TIMEOUT_CLKS (default 250) clocks pass with no detected trigger, the level and the flag are cleared and period timing restarts from zero. A later trigger is then judged on the clocks counted since the last timeout. A trigger detected exactly TIMEOUT_CLKS clocks after the previous one is still evaluated, and it is bad.
- R8: While `osc_fault_i` is high, the level is held at 0 and the OK flag is clear. A trigger detected during that time does not raise the level, but it does restart period timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal time-base clock |
| rst_n | input | 1 | Synchronous active-low power and voltage reset |
| trig_i | input | 1 | Periodic trigger from the host, asynchronous |
| osc_fault_i | input | 1 | Time-base fault flag, active high |
| ok_o | output | 1 | Watchdog-OK flag |
| enable_o | output | 1 | Actuator enable, follows the OK flag |

## Verification
The confidence level is internal, so a wrong level shows up only as the OK flag rising or falling one or more triggers away from its correct point. The bench therefore checks both outputs after every single trigger, on the exact edge where the result appears. A wrong saturation or a window shifted by one clock is seen within two to four trigger periods of steady input. A bad timeout or fault path shows at the first trigger after the event.

// File: rtl/wdt_window_pkg.sv
// Package: shared types and helpers for the windowed watchdog.
// Assumes the confidence level is two bits wide, with saturation limits 0 and 3.
package wdt_window_pkg;

    localparam int CONF_W = 2;

    typedef logic [CONF_W-1:0] conf_t;

    localparam conf_t CONF_FLOOR = conf_t'(0);
    localparam conf_t CONF_CEIL  = conf_t'(3);

    typedef enum logic {
        VERDICT_BAD  = 1'b0,
        VERDICT_GOOD = 1'b1
    } verdict_e;

    // Move the level one step toward the verdict, holding at the limits.
    function automatic conf_t conf_step(input conf_t level, input verdict_e verdict);
        conf_t result;
        result = level;
        if (verdict == VERDICT_GOOD) begin
            if (level != CONF_CEIL) begin
                result = level + conf_t'(1);
            end
        end else begin
            if (level != CONF_FLOOR) begin
                result = level - conf_t'(1);
            end
        end
        return result;
    endfunction

endpackage

// File: rtl/wdt_trig_edge.sv
// Module: trigger synchronizer and rising-edge detector.
// Brings the asynchronous trigger into the clock domain through SYNC_STAGES
// flops, then gives a one-cycle pulse for each low-to-high transition.
// Assumes SYNC_STAGES >= 2 and a trigger that stays low for at least one
// clock between pulses.
module wdt_trig_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic rise_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the raw trigger.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= trig_i;
                end
            end else begin : g_next
                // Later stages pass the value along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Remember the last synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    // One pulse per rising transition of the synchronized trigger.
    always_comb begin
        rise_o = sync_q[LAST] & ~prev_q;
    end

endmodule

// File: rtl/wdt_period_timer.sv
// Module: trigger period counter with missing-trigger timeout.
// Counts clocks since the last detected trigger. period_o is the count
// including the current clock, so a trigger arriving P clocks after the
// previous one sees period_o == P. If TIMEOUT_CLKS clocks pass with no
// trigger, timeout_o pulses for one cycle and the count restarts from zero.
// A trigger on the final clock takes priority over the timeout.
module wdt_period_timer #(
    parameter int TIMEOUT_CLKS = 250,
    parameter int PER_W        = $clog2(TIMEOUT_CLKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    output logic [PER_W-1:0] period_o,
    output logic [PER_W-1:0] count_o,
    output logic             timeout_o
);

    localparam logic [PER_W-1:0] LAST_CNT = PER_W'(TIMEOUT_CLKS - 1);

    logic [PER_W-1:0] cnt_q;

    // Period seen by a trigger in this cycle.
    always_comb begin
        period_o  = cnt_q + PER_W'(1);
        timeout_o = (cnt_q == LAST_CNT) && !rise_i;
        count_o   = cnt_q;
    end

    // Clear on a trigger or a timeout; otherwise count clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (rise_i || timeout_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PER_W'(1);
        end
    end

endmodule

// File: rtl/wdt_window_judge.sv
// Module: window comparator with hysteresis.
// Marks a trigger period good when it lies in [WIN_LO, WIN_HI]. While the OK
// flag is set, both bounds move later by HYST_SHIFT clocks.
// Purely combinational; assumes WIN_HI + HYST_SHIFT fits in PER_W+1 bits.
module wdt_window_judge
    import wdt_window_pkg::*;
#(
    parameter int WIN_LO     = 80,
    parameter int WIN_HI     = 120,
    parameter int HYST_SHIFT = 1,
    parameter int PER_W      = 8
) (
    input  logic             ok_i,
    input  logic [PER_W-1:0] period_i,
    output verdict_e         verdict_o
);

    localparam int CMP_W = PER_W + 1;
    localparam logic [CMP_W-1:0] LO_BASE  = CMP_W'(WIN_LO);
    localparam logic [CMP_W-1:0] HI_BASE  = CMP_W'(WIN_HI);
    localparam logic [CMP_W-1:0] LO_SHIFT = CMP_W'(WIN_LO + HYST_SHIFT);
    localparam logic [CMP_W-1:0] HI_SHIFT = CMP_W'(WIN_HI + HYST_SHIFT);

    logic [CMP_W-1:0] lo_bound;
    logic [CMP_W-1:0] hi_bound;
    logic [CMP_W-1:0] period_ext;

    // Pick the window for the current OK state.
    always_comb begin
        lo_bound = ok_i ? LO_SHIFT : LO_BASE;
        hi_bound = ok_i ? HI_SHIFT : HI_BASE;
    end

    // Compare the period against the selected window.
    always_comb begin
        period_ext = {1'b0, period_i};
        if ((period_ext >= lo_bound) && (period_ext <= hi_bound)) begin
            verdict_o = VERDICT_GOOD;
        end else begin
            verdict_o = VERDICT_BAD;
        end
    end

endmodule

// File: rtl/wdt_confidence.sv
// Module: saturating confidence level and OK set/reset flag.
// On each detected trigger the level moves one step toward the verdict.
// A timeout or a time-base fault clears the level. The flag sets when the
// next level is the ceiling and clears when it is the floor.
// Assumes a single-cycle rise_i pulse per trigger.
module wdt_confidence
    import wdt_window_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rise_i,
    input  verdict_e verdict_i,
    input  logic     timeout_i,
    input  logic     fault_i,
    output conf_t    level_o,
    output logic     ok_o
);

    conf_t level_q;
    conf_t level_d;
    logic  ok_q;
    logic  ok_d;

    // Next level: faults and timeouts win, then trigger verdicts.
    always_comb begin
        if (fault_i || timeout_i) begin
            level_d = CONF_FLOOR;
        end else if (rise_i) begin
            level_d = conf_step(level_q, verdict_i);
        end else begin
            level_d = level_q;
        end
    end

    // Set/reset flag driven by the limits of the next level.
    always_comb begin
        if (level_d == CONF_CEIL) begin
            ok_d = 1'b1;
        end else if (level_d == CONF_FLOOR) begin
            ok_d = 1'b0;
        end else begin
            ok_d = ok_q;
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= CONF_FLOOR;
            ok_q    <= 1'b0;
        end else begin
            level_q <= level_d;
            ok_q    <= ok_d;
        end
    end

    // Expose the state.
    always_comb begin
        level_o = level_q;
        ok_o    = ok_q;
    end

endmodule

// File: rtl/wdt_window_supervisor.sv
// Module: windowed trigger watchdog top level.
// Synchronizes the trigger, times its period, judges it against a window
// that moves once OK is set, and keeps a saturating confidence level that
// drives the OK and enable outputs. Reset is synchronous and active-low.
// Assumes clk is the independent internal time base.
module wdt_window_supervisor
    import wdt_window_pkg::*;
#(
    parameter int WIN_LO       = 80,
    parameter int WIN_HI       = 120,
    parameter int HYST_SHIFT   = 1,
    parameter int TIMEOUT_CLKS = 250,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic osc_fault_i,
    output logic ok_o,
    output logic enable_o
);

    localparam int PER_W = $clog2(TIMEOUT_CLKS + 1);

    logic             rise_pulse;
    logic [PER_W-1:0] period_val;
    logic [PER_W-1:0] period_cnt;
    logic             timeout_pulse;
    verdict_e         verdict;
    conf_t            conf_level;
    logic             ok_flag;

    wdt_trig_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_i),
        .rise_o (rise_pulse)
    );

    wdt_period_timer #(
        .TIMEOUT_CLKS(TIMEOUT_CLKS),
        .PER_W       (PER_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise_pulse),
        .period_o  (period_val),
        .count_o   (period_cnt),
        .timeout_o (timeout_pulse)
    );

    wdt_window_judge #(
        .WIN_LO    (WIN_LO),
        .WIN_HI    (WIN_HI),
        .HYST_SHIFT(HYST_SHIFT),
        .PER_W     (PER_W)
    ) u_judge (
        .ok_i      (ok_flag),
        .period_i  (period_val),
        .verdict_o (verdict)
    );

    wdt_confidence u_conf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise_pulse),
        .verdict_i (verdict),
        .timeout_i (timeout_pulse),
        .fault_i   (osc_fault_i),
        .level_o   (conf_level),
        .ok_o      (ok_flag)
    );

    // Both outputs present the OK flag.
    always_comb begin
        ok_o     = ok_flag;
        enable_o = ok_flag;
    end

endmodule

// File: rtl/wdt_window_checker.sv
// Module: property checker for the windowed watchdog, bound to the top.
// Watches the ports and the internal pulses and level between sub-blocks.
module wdt_window_checker #(
    parameter int TIMEOUT_CLKS = 250,
    parameter int PER_W        = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             osc_fault_i,
    input logic             ok_o,
    input logic             enable_o,
    input logic             rise,
    input logic             timeout,
    input logic [1:0]       conf,
    input logic [PER_W-1:0] count
);

    // R1: reset clears level and flag.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (!ok_o && conf == 2'd0));

    // R2: the edge detector never gives two pulses in a row.
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    // R4: without a trigger, timeout or fault, the level holds.
    p_level_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && !timeout && !osc_fault_i) |=> $stable(conf));

    // R4: a trigger moves the level by at most one, with no wrap.
    p_level_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !timeout && !osc_fault_i) |=>
            ($stable(conf) ||
             ({1'b0, conf} == {1'b0, $past(conf)} + 3'd1) ||
             ({1'b0, conf} + 3'd1 == {1'b0, $past(conf)})));

    // R5: the flag rises only at the top level and falls only at zero.
    p_ok_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok_o) |-> conf == 2'd3);

    p_ok_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ok_o) |-> conf == 2'd0);

    p_enable_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable_o) |-> conf == 2'd3);

    // R7: a timeout clears the level and the flag.
    p_timeout_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> (!ok_o && conf == 2'd0));

    // R7: the period count stays below the timeout value.
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count < PER_W'(TIMEOUT_CLKS));

    // R8: a fault clears the level and the flag.
    p_fault_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        osc_fault_i |=> (!ok_o && conf == 2'd0));

endmodule

bind wdt_window_supervisor wdt_window_checker #(
    .TIMEOUT_CLKS(TIMEOUT_CLKS),
    .PER_W       (PER_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_fault_i (osc_fault_i),
    .ok_o        (ok_o),
    .enable_o    (enable_o),
    .rise        (rise_pulse),
    .timeout     (timeout_pulse),
    .conf        (conf_level),
    .count       (period_cnt)
);

// File: tb/wdt_window_supervisor_tb.sv
module wdt_window_supervisor_tb;

    localparam int LO = 80;
    localparam int HI = 120;
    localparam int TO = 250;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_i = 1'b0;
    logic osc_fault_i = 1'b0;
    logic ok_o;
    logic enable_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    int  m_conf  = 0;
    bit  m_ok    = 1'b0;
    int  prev_p  = 1;

    always #10 clk = ~clk;

    wdt_window_supervisor u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (trig_i),
        .osc_fault_i (osc_fault_i),
        .ok_o        (ok_o),
        .enable_o    (enable_o)
    );

    task automatic check(input string req, input bit got, input bit exp, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %0b expected %0b (t=%0t)", req, what, got, exp, $time);
        end
    endtask

    // Model of one evaluated trigger whose period since the last detection is period.
    task automatic model_eval(input int period, input bit fault);
        int  m;
        bit  good;
        m = period;
        if (fault) begin
            m_conf = 0;
            m_ok   = 1'b0;
            return;
        end
        while (m > TO) begin
            m_conf = 0;
            m_ok   = 1'b0;
            m      = m - TO;
        end
        good = (m >= LO + int'(m_ok)) && (m <= HI + int'(m_ok));
        if (good && m_conf < 3) m_conf++;
        else if (!good && m_conf > 0) m_conf--;
        if (m_conf == 3) m_ok = 1'b1;
        else if (m_conf == 0) m_ok = 1'b0;
    endtask

    // Raise the trigger now (at a falling edge), check the outputs once the
    // result is visible, then wait so the next rise comes p clocks later.
    task automatic send(input int p, input bit hold, input bit fault, input string req);
        trig_i = 1'b1;
        if (fault) osc_fault_i = 1'b1;
        model_eval(prev_p, fault);
        for (int i = 1; i <= p; i++) begin
            @(negedge clk);
            if (!hold && i == 2) trig_i = 1'b0;
            if (hold && i == p - 2) trig_i = 1'b0;
            if (i == 3) begin
                check(req, ok_o, m_ok, "ok_o");
                check(req, enable_o, m_ok, "enable_o");
                osc_fault_i = 1'b0;
            end
        end
        prev_p = p;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        trig_i = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", ok_o, 1'b0, "ok_o in reset");
        check("R1", enable_o, 1'b0, "enable_o in reset");
        rst_n  = 1'b1;
        m_conf = 0;
        m_ok   = 1'b0;
        repeat (3) @(negedge clk);
        // First trigger after reset has a short, bad period.
        prev_p = 1;
        send(100, 1'b0, 1'b0, "R1");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", ok_o, 1'b0, "ok_o after reset");
        check("R1", enable_o, 1'b0, "enable_o after reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        send(100, 1'b0, 1'b0, "R2");

        // R3 R4 R5 R6: sweep periods across both window edges.
        for (int p = 74; p <= 128; p++) begin
            for (int k = 0; k < 5; k++) send(p, 1'b0, 1'b0, "R3");
        end

        // R6: low bound moves with OK set.
        for (int k = 0; k < 4; k++) send(100, 1'b0, 1'b0, "R5");
        for (int k = 0; k < 3; k++) send(80, 1'b0, 1'b0, "R6");
        for (int k = 0; k < 4; k++) send(100, 1'b0, 1'b0, "R6");
        for (int k = 0; k < 5; k++) send(121, 1'b0, 1'b0, "R6");
        send(100, 1'b0, 1'b0, "R6");

        // R4: saturation at the top and at zero.
        for (int k = 0; k < 6; k++) send(100, 1'b0, 1'b0, "R4");
        for (int k = 0; k < 3; k++) send(130, 1'b0, 1'b0, "R4");
        for (int k = 0; k < 4; k++) send(130, 1'b0, 1'b0, "R4");
        for (int k = 0; k < 4; k++) send(100, 1'b0, 1'b0, "R4");

        // R7: missing trigger, restart, repeated timeouts, exact limit.
        for (int k = 0; k < 4; k++) send(100, 1'b0, 1'b0, "R7");
        send(260, 1'b0, 1'b0, "R7");
        send(100, 1'b0, 1'b0, "R7");
        for (int k = 0; k < 4; k++) send(100, 1'b0, 1'b0, "R7");
        send(350, 1'b0, 1'b0, "R7");
        send(100, 1'b0, 1'b0, "R7");
        for (int k = 0; k < 4; k++) send(100, 1'b0, 1'b0, "R7");
        send(600, 1'b0, 1'b0, "R7");
        send(250, 1'b0, 1'b0, "R7");
        for (int k = 0; k < 4; k++) send(100, 1'b0, 1'b0, "R7");
        send(500, 1'b0, 1'b0, "R7");
        for (int k = 0; k < 4; k++) send(100, 1'b0, 1'b0, "R7");

        // R8: fault clears OK and ignores the trigger it overlaps.
        for (int k = 0; k < 4; k++) send(100, 1'b0, 1'b0, "R8");
        send(100, 1'b0, 1'b1, "R8");
        for (int k = 0; k < 4; k++) send(100, 1'b0, 1'b0, "R8");
        send(100, 1'b0, 1'b1, "R8");
        send(100, 1'b0, 1'b1, "R8");
        for (int k = 0; k < 4; k++) send(100, 1'b0, 1'b0, "R8");

        // R2: held trigger evaluated once per rise.
        for (int k = 0; k < 6; k++) send(100, 1'b1, 1'b0, "R2");
        for (int k = 0; k < 4; k++) send(130, 1'b1, 1'b0, "R2");

        // R1: reset while OK is set.
        for (int k = 0; k < 4; k++) send(100, 1'b0, 1'b0, "R1");
        do_reset();
        for (int k = 0; k < 4; k++) send(100, 1'b0, 1'b0, "R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule